// File: doc/BRIEF.md
# Reference-Compare Condition and Counter Unit

This block is a shared resource that sits beside one or more sequencers. It turns a set of input values and a set of internal counters into condition flags. Each source, whether an input or a counter, is compared against two reference values of its own. Each comparison gives a less, an equal and a greater flag. The flags are registered, so a sequencer always reads a clean, glitch-free flag vector.

The counters are changed only by a command bus that several sequencers share. A command names one counter and one of four operations: load one of the counter's references, add one of them, increment, or decrement. Arithmetic wraps modulo 2^W.

Every output lane has a selector. The selector picks one counter's value or a constant for that lane. A parameter mask decides, lane by lane, whether the output is registered or combinational. The references, the initial counter values, the constants and the selectors are static configuration inputs.

Top module: `refcmp_unit`

## Requirements
- R1: For input i, the flags at bit 6*i+k of `cond_flags` give the unsigned comparison of the input against its references. k=0 is below ref0, k=1 is equal to ref0, k=2 is above ref0, k=3 is below ref1, k=4 is equal to ref1 and k=5 is above ref1. The flags appear one clock after the input is sampled.
- R2: Counter c is source N_IN+c. It has the same six-flag layout, compared against its own references. The flags reflect the counter one clock after the counter's register changes.
- R3: Operation code 0 loads the counter with ref0 when `cmd_rsel` is 0, or with ref1 when `cmd_rsel` is 1.
- R4: Operation code 1 adds the selected reference to the counter, modulo 2^W.
- R5: Operation code 2 increments the counter and operation code 3 decrements it. Both wrap, so the maximum goes to 0 and 0 goes to the maximum.
- R6: When several valid commands name the same counter in one cycle, only the command on the lowest-numbered port takes effect.
- R7: A counter that no valid command names keeps its value. A command whose index is N_CNT or higher changes no counter.
- R8: An output lane whose selector is below N_CNT carries that counter's value. Any other selector value gives the lane's constant.
- R9: A lane whose bit in OUT_REG_MASK is 1 shows its selected value one clock later. A lane whose bit is 0 shows it in the same cycle.
- R10: While `rst_n` is low at a clock edge, every counter takes its initial value, all flags are 0 and the registered lanes are 0. Commands are ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | N_IN*W | Input values, input i at bits [i*W +: W] |
| cfg_ref0 | input | (N_IN+N_CNT)*W | First reference of each source |
| cfg_ref1 | input | (N_IN+N_CNT)*W | Second reference of each source |
| cfg_init | input | N_CNT*W | Counter values applied during reset |
| cfg_const | input | N_OUT*W | Constant of each output lane |
| cfg_osel | input | N_OUT*SW | Selector of each output lane |
| cmd_vld | input | N_CMD | Command valid, one per port |
| cmd_idx | input | N_CMD*IW | Target counter of each port |
| cmd_op | input | N_CMD*2 | Operation code of each port |
| cmd_rsel | input | N_CMD | Reference choice of each port |
| cond_flags | output | (N_IN+N_CNT)*6 | Registered comparison flags |
| out_data | output | N_OUT*W | Output lanes |

## Verification
Fixed-seed random cycles draw input values mostly from the references and their neighbours. This is what makes the equal flags and the below/above boundaries appear, and separates a strict comparison from an inclusive one. The random commands often hit the same counter from both ports, which separates the correct port priority from the reversed one. Directed cycles drive counters across the top and the bottom of their range, add a large reference so the sum overflows, issue a command to an index that does not exist, and issue commands during reset. Each output lane is compared each cycle against the model's value. A registered lane is checked one clock late and a combinational lane in the same cycle, so a lane with the wrong latency shows up at once.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_ADD  = 2'd1,
      OP_INC  = 2'd2,
      OP_DEC  = 2'd3
   } cnt_op_e;

   localparam int FLAGS_PER_SRC = 6;
   localparam int FL_LT = 0;
   localparam int FL_EQ = 1;
   localparam int FL_GT = 2;
   localparam int FL_REF1_OFS = 3;
endpackage

// File: rtl/refcmp_cmp.sv
module refcmp_cmp #(
   parameter int W = 8
) (
   input  logic [W-1:0] val,
   input  logic [W-1:0] ref0,
   input  logic [W-1:0] ref1,
   output logic [refcmp_pkg::FLAGS_PER_SRC-1:0] flags
);
   import refcmp_pkg::*;

   always_comb begin
      flags = '0;
      flags[FL_LT] = val < ref0;
      flags[FL_EQ] = val == ref0;
      flags[FL_GT] = val > ref0;
      flags[FL_REF1_OFS + FL_LT] = val < ref1;
      flags[FL_REF1_OFS + FL_EQ] = val == ref1;
      flags[FL_REF1_OFS + FL_GT] = val > ref1;
   end
endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
   parameter int W      = 8,
   parameter int N_CMD  = 2,
   parameter int IW     = 2,
   parameter int MY_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     init,
   input  logic [W-1:0]     ref0,
   input  logic [W-1:0]     ref1,
   input  logic [N_CMD-1:0] cmd_vld,
   input  logic [N_CMD*IW-1:0] cmd_idx,
   input  logic [N_CMD*2-1:0]  cmd_op,
   input  logic [N_CMD-1:0] cmd_rsel,
   output logic [W-1:0]     cnt
);
   import refcmp_pkg::*;

   logic          win_hit;
   cnt_op_e       win_op;
   logic          win_rsel;
   logic [W-1:0]  operand;
   logic [W-1:0]  cnt_nxt;

   // scan from the top port down so the lowest matching port is applied last
   always_comb begin
      win_hit  = 1'b0;
      win_op   = OP_INC;
      win_rsel = 1'b0;
      for (int p = N_CMD - 1; p >= 0; p--) begin
         if (cmd_vld[p] && (cmd_idx[p*IW +: IW] == IW'(MY_IDX))) begin
            win_hit  = 1'b1;
            win_op   = cnt_op_e'(cmd_op[p*2 +: 2]);
            win_rsel = cmd_rsel[p];
         end
      end
   end

   assign operand = win_rsel ? ref1 : ref0;

   always_comb begin
      unique case (win_op)
         OP_LOAD: cnt_nxt = operand;
         OP_ADD:  cnt_nxt = cnt + operand;
         OP_INC:  cnt_nxt = cnt + W'(1);
         default: cnt_nxt = cnt - W'(1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= init;
      else if (win_hit)
         cnt <= cnt_nxt;
   end

   // R3
   load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && win_op == OP_LOAD) |=> cnt == $past(operand));
   // R4
   add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && win_op == OP_ADD) |=> cnt == W'($past(cnt) + $past(operand)));
   // R5
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && win_op == OP_INC) |=> cnt == W'($past(cnt) + W'(1)));
   // R5
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_hit && win_op == OP_DEC) |=> cnt == W'($past(cnt) - W'(1)));
   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |=> $stable(cnt));
endmodule

// File: rtl/refcmp_outsel.sv
module refcmp_outsel #(
   parameter int W     = 8,
   parameter int N_CNT = 3,
   parameter int SW    = 2
) (
   input  logic [N_CNT*W-1:0] cnt_all,
   input  logic [W-1:0]       cst,
   input  logic [SW-1:0]      sel,
   output logic [W-1:0]       val
);
   always_comb begin
      val = cst;
      for (int c = 0; c < N_CNT; c++) begin
         if (sel == SW'(c)) val = cnt_all[c*W +: W];
      end
   end
endmodule

// File: rtl/refcmp_unit.sv
module refcmp_unit #(
   parameter int          W            = 8,
   parameter int          N_IN         = 2,
   parameter int          N_CNT        = 3,
   parameter int          N_CMD        = 2,
   parameter int          N_OUT        = 3,
   parameter int unsigned OUT_REG_MASK = 32'd5,
   localparam int NSRC = N_IN + N_CNT,
   localparam int IW   = (N_CNT > 1) ? $clog2(N_CNT) + 1 : 1,
   localparam int SW   = $clog2(N_CNT + 1),
   localparam int FPS  = refcmp_pkg::FLAGS_PER_SRC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_IN*W-1:0]   in_data,
   input  logic [NSRC*W-1:0]   cfg_ref0,
   input  logic [NSRC*W-1:0]   cfg_ref1,
   input  logic [N_CNT*W-1:0]  cfg_init,
   input  logic [N_OUT*W-1:0]  cfg_const,
   input  logic [N_OUT*SW-1:0] cfg_osel,
   input  logic [N_CMD-1:0]    cmd_vld,
   input  logic [N_CMD*IW-1:0] cmd_idx,
   input  logic [N_CMD*2-1:0]  cmd_op,
   input  logic [N_CMD-1:0]    cmd_rsel,
   output logic [NSRC*FPS-1:0] cond_flags,
   output logic [N_OUT*W-1:0]  out_data
);
   generate
      if (W < 1 || N_IN < 1 || N_CNT < 1 || N_CMD < 1 || N_OUT < 1 || N_OUT > 32)
         $error("refcmp_unit: parameter out of range");
   endgenerate

   logic [N_CNT*W-1:0]  cnt_all;
   logic [NSRC*FPS-1:0] flags_c;

   genvar gi;
   generate
      for (gi = 0; gi < N_CNT; gi++) begin : g_cnt
         refcmp_counter #(.W(W), .N_CMD(N_CMD), .IW(IW), .MY_IDX(gi)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .init     (cfg_init[gi*W +: W]),
            .ref0     (cfg_ref0[(N_IN+gi)*W +: W]),
            .ref1     (cfg_ref1[(N_IN+gi)*W +: W]),
            .cmd_vld  (cmd_vld),
            .cmd_idx  (cmd_idx),
            .cmd_op   (cmd_op),
            .cmd_rsel (cmd_rsel),
            .cnt      (cnt_all[gi*W +: W])
         );
      end

      for (gi = 0; gi < NSRC; gi++) begin : g_src
         logic [W-1:0] src_val;
         if (gi < N_IN) begin : g_in
            assign src_val = in_data[gi*W +: W];
         end else begin : g_ctr
            assign src_val = cnt_all[(gi-N_IN)*W +: W];
         end
         refcmp_cmp #(.W(W)) u_cmp (
            .val   (src_val),
            .ref0  (cfg_ref0[gi*W +: W]),
            .ref1  (cfg_ref1[gi*W +: W]),
            .flags (flags_c[gi*FPS +: FPS])
         );

         // R1
         flag_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> $countones(cond_flags[gi*FPS +: 3]) == 1);
         // R2
         flag_onehot1_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> $countones(cond_flags[gi*FPS+3 +: 3]) == 1);
      end

      for (gi = 0; gi < N_OUT; gi++) begin : g_out
         logic [W-1:0] lane_val;
         refcmp_outsel #(.W(W), .N_CNT(N_CNT), .SW(SW)) u_sel (
            .cnt_all (cnt_all),
            .cst     (cfg_const[gi*W +: W]),
            .sel     (cfg_osel[gi*SW +: SW]),
            .val     (lane_val)
         );
         if (OUT_REG_MASK[gi]) begin : g_reg
            always_ff @(posedge clk) begin
               if (!rst_n) out_data[gi*W +: W] <= '0;
               else        out_data[gi*W +: W] <= lane_val;
            end
         end else begin : g_comb
            assign out_data[gi*W +: W] = lane_val;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cond_flags <= '0;
      else        cond_flags <= flags_c;
   end
endmodule

// File: tb/refcmp_unit_bench.sv
module refcmp_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8, N_IN = 2, N_CNT = 3, N_CMD = 2, N_OUT = 3;
   localparam int unsigned MASK = 32'd5;
   localparam int NSRC = N_IN + N_CNT;
   localparam int IW = 3, SW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [W-1:0] inv [N_IN];
   logic [W-1:0] r0 [NSRC];
   logic [W-1:0] r1 [NSRC];
   logic [W-1:0] ini [N_CNT];
   logic [W-1:0] cst [N_OUT];
   logic [SW-1:0] osel [N_OUT];
   logic [N_CMD-1:0] cv, cr;
   logic [IW-1:0] ci [N_CMD];
   logic [1:0] co [N_CMD];

   logic [N_IN*W-1:0] in_data;
   logic [NSRC*W-1:0] cfg_ref0, cfg_ref1;
   logic [N_CNT*W-1:0] cfg_init;
   logic [N_OUT*W-1:0] cfg_const;
   logic [N_OUT*SW-1:0] cfg_osel;
   logic [N_CMD*IW-1:0] cmd_idx;
   logic [N_CMD*2-1:0] cmd_op;
   logic [NSRC*6-1:0] cond_flags;
   logic [N_OUT*W-1:0] out_data;

   always_comb begin
      for (int i = 0; i < N_IN; i++) in_data[i*W +: W] = inv[i];
      for (int s = 0; s < NSRC; s++) begin
         cfg_ref0[s*W +: W] = r0[s];
         cfg_ref1[s*W +: W] = r1[s];
      end
      for (int c = 0; c < N_CNT; c++) cfg_init[c*W +: W] = ini[c];
      for (int o = 0; o < N_OUT; o++) begin
         cfg_const[o*W +: W] = cst[o];
         cfg_osel[o*SW +: SW] = osel[o];
      end
      for (int p = 0; p < N_CMD; p++) begin
         cmd_idx[p*IW +: IW] = ci[p];
         cmd_op[p*2 +: 2] = co[p];
      end
   end

   refcmp_unit #(.W(W), .N_IN(N_IN), .N_CNT(N_CNT), .N_CMD(N_CMD), .N_OUT(N_OUT),
                 .OUT_REG_MASK(MASK)) u_refcmp_unit (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .cfg_ref0(cfg_ref0), .cfg_ref1(cfg_ref1),
      .cfg_init(cfg_init), .cfg_const(cfg_const), .cfg_osel(cfg_osel), .cmd_vld(cv),
      .cmd_idx(cmd_idx), .cmd_op(cmd_op), .cmd_rsel(cr), .cond_flags(cond_flags),
      .out_data(out_data));

   int n_chk = 0, n_fail = 0;
   logic [W-1:0] m_cnt [N_CNT];
   logic [W-1:0] m_oreg [N_OUT];
   logic [NSRC*6-1:0] m_flags;

   function automatic logic [5:0] cmp6(logic [W-1:0] v, logic [W-1:0] a, logic [W-1:0] b);
      return {v > b, v == b, v < b, v > a, v == a, v < a};
   endfunction

   function automatic logic [W-1:0] lane(int o);
      if (osel[o] < SW'(N_CNT)) return m_cnt[osel[o]];
      return cst[o];
   endfunction

   task automatic check(string tag);
      for (int s = 0; s < NSRC; s++) begin
         n_chk++;
         if (cond_flags[s*6 +: 6] !== m_flags[s*6 +: 6]) begin
            n_fail++;
            $display("FAIL %s %s src %0d got %b exp %b", tag, (s < N_IN) ? "R1" : "R2",
                     s, cond_flags[s*6 +: 6], m_flags[s*6 +: 6]);
         end
      end
      for (int o = 0; o < N_OUT; o++) begin
         logic [W-1:0] e;
         e = MASK[o] ? m_oreg[o] : lane(o);
         n_chk++;
         if (out_data[o*W +: W] !== e) begin
            n_fail++;
            $display("FAIL %s %s lane %0d got %h exp %h", tag, MASK[o] ? "R9" : "R8",
                     o, out_data[o*W +: W], e);
         end
      end
   endtask

   // one clock: predict with current stimulus, clock, then check at the falling edge
   task automatic cycle(string tag);
      logic [NSRC*6-1:0] nf;
      logic [W-1:0] nc [N_CNT];
      logic [W-1:0] no [N_OUT];
      for (int s = 0; s < NSRC; s++)
         nf[s*6 +: 6] = cmp6((s < N_IN) ? inv[s] : m_cnt[s-N_IN], r0[s], r1[s]);
      for (int o = 0; o < N_OUT; o++) no[o] = lane(o);
      for (int c = 0; c < N_CNT; c++) begin
         logic done;
         logic [W-1:0] opd;
         nc[c] = m_cnt[c];
         done = 1'b0;
         for (int p = 0; p < N_CMD; p++) begin
            if (!done && cv[p] && ci[p] == IW'(c)) begin
               done = 1'b1;
               opd = cr[p] ? r1[N_IN+c] : r0[N_IN+c];
               case (co[p])
                  2'd0: nc[c] = opd;
                  2'd1: nc[c] = m_cnt[c] + opd;
                  2'd2: nc[c] = m_cnt[c] + 8'd1;
                  default: nc[c] = m_cnt[c] - 8'd1;
               endcase
            end
         end
         if (!rst_n) nc[c] = ini[c];
      end
      if (!rst_n) begin
         nf = '0;
         for (int o = 0; o < N_OUT; o++) no[o] = '0;
      end
      @(posedge clk);
      m_flags = nf;
      for (int c = 0; c < N_CNT; c++) m_cnt[c] = nc[c];
      for (int o = 0; o < N_OUT; o++) m_oreg[o] = no[o];
      @(negedge clk);
      check(tag);
   endtask

   task automatic cmd(int p, int idx, int op, int rs);
      cv[p] = 1'b1;
      ci[p] = IW'(idx);
      co[p] = 2'(op);
      cr[p] = 1'(rs);
   endtask

   task automatic idle();
      cv = '0;
      cr = '0;
      for (int p = 0; p < N_CMD; p++) begin
         ci[p] = '0;
         co[p] = '0;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired, no requirement completed");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      idle();
      for (int i = 0; i < N_IN; i++) inv[i] = 8'h40;
      for (int s = 0; s < NSRC; s++) begin
         r0[s] = 8'h40;
         r1[s] = 8'hC0;
      end
      ini[0] = 8'h10; ini[1] = 8'h20; ini[2] = 8'h30;
      cst[0] = 8'hA5; cst[1] = 8'h5A; cst[2] = 8'h3C;
      osel[0] = 2'd0; osel[1] = 2'd1; osel[2] = 2'd3;
      for (int c = 0; c < N_CNT; c++) m_cnt[c] = 'x;
      @(negedge clk);
      // R10: commands during reset have no effect
      cmd(0, 0, 2, 0);
      cmd(1, 1, 0, 1);
      cycle("R10 reset");
      cycle("R10 reset");
      idle();
      rst_n = 1'b1;
      cycle("R1 R2 first");
      // R3 load both refs
      r0[N_IN+0] = 8'h07; r1[N_IN+1] = 8'hF0;
      cmd(0, 0, 0, 0); cmd(1, 1, 0, 1);
      cycle("R3 load");
      // R4 add overflow: 0xF0 + 0xF0
      idle(); cmd(0, 1, 1, 1);
      cycle("R4 add wrap");
      // R5 increment wrap through the top
      r0[N_IN+2] = 8'hFF;
      idle(); cmd(0, 2, 0, 0);
      cycle("R5 load max");
      idle(); cmd(1, 2, 2, 0);
      cycle("R5 inc wrap");
      idle(); cmd(0, 2, 3, 0);
      cycle("R5 dec wrap");
      // R6 both ports on counter 0: port 0 increment must win over port 1 load
      idle(); cmd(0, 0, 2, 0); cmd(1, 0, 0, 1);
      cycle("R6 priority");
      // R7 nonexistent indices change nothing
      idle(); cmd(0, 3, 0, 0); cmd(1, 7, 3, 1);
      cycle("R7 bad index");
      idle();
      cycle("R7 idle hold");
      // R1 equal-to-reference corner on inputs
      inv[0] = r0[0]; inv[1] = r1[1];
      cycle("R1 equal");
      // R8 lane 1 switched to its constant, lane 0 to counter 2
      osel[1] = 2'd3; osel[0] = 2'd2;
      cycle("R8 R9 select");
      osel[1] = 2'd2;
      cycle("R8 R9 select");
      for (int n = 0; n < 3000; n++) begin
         if (($urandom % 64) == 0) begin
            for (int s = 0; s < NSRC; s++) begin
               r0[s] = 8'($urandom);
               r1[s] = 8'($urandom);
            end
            for (int o = 0; o < N_OUT; o++) osel[o] = 2'($urandom);
         end
         for (int i = 0; i < N_IN; i++) begin
            case ($urandom % 5)
               0: inv[i] = r0[i];
               1: inv[i] = r1[i];
               2: inv[i] = r0[i] + 8'd1;
               3: inv[i] = r1[i] - 8'd1;
               default: inv[i] = 8'($urandom);
            endcase
         end
         for (int p = 0; p < N_CMD; p++) begin
            cv[p] = 1'($urandom);
            ci[p] = IW'($urandom % 4);
            co[p] = 2'($urandom);
            cr[p] = 1'($urandom);
         end
         if (($urandom % 4) == 0) ci[1] = ci[0];
         cycle("R2-R7 random");
      end
      idle();
      rst_n = 1'b0;
      cycle("R10 late reset");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule